// File: doc/BRIEF.md
# Ethernet PHY Status Register with Gated Override Writes

This block holds the status word of an Ethernet transceiver's management register space. It also holds the single control flag that unlocks writes to the normally read-only status bits. A management-frame front end drives it with a 5-bit register address, a read strobe, a write strobe and 16 bits of write data. The block answers reads combinationally in the same cycle as the strobe. Separately, an auto-negotiation engine supplies three live signals: enabled, complete and restarting.

The status word combines several kinds of bit. Its upper five and lower five bits are fixed capability constants, set by parameters. The reserved bits always read as zero. The negotiation-complete bit latches high and is cleared by a read. The preamble-suppression bit can only be written while the override flag is set. That last bit drives an output that tells the frame receiver it may accept management frames with no preamble. Every other register address reads zero and ignores writes.

Top module: `phy_stat_reg`

## Requirements
- R1: Status bits 10 down to 7 are reserved and read as zero on every status read, whatever data was written to them.
- R2: A write to the status address loads write-data bit 6 into status bit 6 only when the override flag was already one before that write. Otherwise status bit 6 keeps its value.
- R3: Status bit 6 resets to zero, and output `psup_en` always equals the value that status bit 6 reads.
- R4: The override flag is bit 15 of the extended-control address. It resets to zero and is loaded from write-data bit 15 by every write to that address. A read there returns the flag in bit 15 and zero in bits 14 to 0.
- R5: While `an_en` is low, status bit 5 reads zero and the held completion is discarded, so it is not seen after `an_en` returns high.
- R6: With `an_en` high, a cycle with `an_done` high and `an_restart` low sets status bit 5. It stays one after `an_done` falls, until a status read.
- R7: A high `an_restart` does not clear a held status bit 5, and completion is not recorded in any cycle where `an_restart` is high.
- R8: At the clock edge that ends a status read, the held bit 5 is reloaded with the live completion condition. A second read therefore returns the live state.
- R9: Status bits 15 to 11 equal parameter `CAP_HI` and bits 4 to 0 equal `CAP_LO`. Writes never change them.
- R10: Addresses other than the status address (default 1) and the extended-control address (default 16) read zero, and writes to them change no state.
- R11: `rd_data` is zero in any cycle where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe; the read completes at the next clock edge |
| wr_en | input | 1 | Write strobe; takes effect at the next clock edge |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid in the strobe cycle |
| an_en | input | 1 | Auto-negotiation enabled |
| an_done | input | 1 | Auto-negotiation complete, live |
| an_restart | input | 1 | Auto-negotiation restarting |
| psup_en | output | 1 | Accept management frames without preamble |

## Verification
A wrong override flag or preamble-suppression state shows on `psup_en` one edge after the write that should or should not have changed it. The same wrong state appears on the next read of either register. A wrong completion latch is only visible on bit 5 of a status read, so each latch scenario ends with two back-to-back reads: the first shows the held value and the second the value reloaded at the read edge. Sweeping every address with several data patterns, once with the flag clear and once with it set, shows any write that leaks into a constant, reserved or unmapped bit at the next read.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int CAP_W    = 5;
    localparam int RSVD_W   = 4;
    localparam int BIT_OVR  = 15;
    localparam int BIT_PSUP = 6;
    localparam int BIT_ANC  = 5;

    typedef struct packed {
        logic ovr;
        logic psup;
    } ctl_t;
endpackage

// File: rtl/phy_stat_anc.sv
module phy_stat_anc (
    input  logic clk,
    input  logic rst_n,
    input  logic an_en,
    input  logic an_done,
    input  logic an_restart,
    input  logic rd_hit,
    output logic anc_q,
    output logic anc_bit
);
    logic anc_d;
    logic live;

    always_comb begin
        live = an_en & an_done & ~an_restart;
        if (!an_en) begin
            anc_d = 1'b0;
        end else if (rd_hit) begin
            anc_d = live;
        end else begin
            anc_d = anc_q | live;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            anc_q <= 1'b0;
        end else begin
            anc_q <= anc_d;
        end
    end

    assign anc_bit = an_en & anc_q;
endmodule

// File: rtl/phy_stat_ovr.sv
module phy_stat_ovr
    import phy_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stat,
    input  logic wr_xctl,
    input  logic wr_ovr_bit,
    input  logic wr_psup_bit,
    output ctl_t ctl_q
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_xctl) begin
            ctl_d.ovr = wr_ovr_bit;
        end
        if (wr_stat && ctl_q.ovr) begin
            ctl_d.psup = wr_psup_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/phy_stat_rdmux.sv
module phy_stat_rdmux
    import phy_stat_pkg::*;
#(
    parameter logic [CAP_W-1:0] CAP_HI = 5'b01111,
    parameter logic [CAP_W-1:0] CAP_LO = 5'b01001
) (
    input  logic              rd_en,
    input  logic              sel_stat,
    input  logic              sel_xctl,
    input  ctl_t              ctl,
    input  logic              anc_bit,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] xctl_word;

    always_comb begin
        stat_word = {CAP_HI, {RSVD_W{1'b0}}, ctl.psup, anc_bit, CAP_LO};
        xctl_word = '0;
        xctl_word[BIT_OVR] = ctl.ovr;
        if (!rd_en) begin
            rd_data = '0;
        end else if (sel_stat) begin
            rd_data = stat_word;
        end else if (sel_xctl) begin
            rd_data = xctl_word;
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/phy_stat_reg.sv
module phy_stat_reg
    import phy_stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'd1,
    parameter logic [ADDR_W-1:0] XCTL_ADDR = 5'd16,
    parameter logic [CAP_W-1:0]  CAP_HI    = 5'b01111,
    parameter logic [CAP_W-1:0]  CAP_LO    = 5'b01001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              an_en,
    input  logic              an_done,
    input  logic              an_restart,
    output logic              psup_en
);
    logic sel_stat;
    logic sel_xctl;
    logic rd_hit;
    logic anc_q;
    logic anc_bit;
    ctl_t ctl_q;
    logic ovr_now;
    logic unused_wr_bits;

    assign sel_stat = (reg_addr == STAT_ADDR);
    assign sel_xctl = (reg_addr == XCTL_ADDR);
    assign rd_hit   = rd_en & sel_stat;
    assign unused_wr_bits = ^{wr_data[14:7], wr_data[5:0]};

    phy_stat_anc i_anc (
        .clk        (clk),
        .rst_n      (rst_n),
        .an_en      (an_en),
        .an_done    (an_done),
        .an_restart (an_restart),
        .rd_hit     (rd_hit),
        .anc_q      (anc_q),
        .anc_bit    (anc_bit)
    );

    phy_stat_ovr i_ovr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stat     (wr_en & sel_stat),
        .wr_xctl     (wr_en & sel_xctl),
        .wr_ovr_bit  (wr_data[BIT_OVR]),
        .wr_psup_bit (wr_data[BIT_PSUP]),
        .ctl_q       (ctl_q)
    );

    phy_stat_rdmux #(
        .CAP_HI (CAP_HI),
        .CAP_LO (CAP_LO)
    ) i_rdmux (
        .rd_en    (rd_en),
        .sel_stat (sel_stat),
        .sel_xctl (sel_xctl),
        .ctl      (ctl_q),
        .anc_bit  (anc_bit),
        .rd_data  (rd_data)
    );

    assign ovr_now = ctl_q.ovr;
    assign psup_en = ctl_q.psup;
endmodule

// File: rtl/phy_stat_chk.sv
module phy_stat_chk
    import phy_stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'd1,
    parameter logic [ADDR_W-1:0] XCTL_ADDR = 5'd16,
    parameter logic [CAP_W-1:0]  CAP_HI    = 5'b01111,
    parameter logic [CAP_W-1:0]  CAP_LO    = 5'b01001
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              an_en,
    input logic              an_done,
    input logic              an_restart,
    input logic              psup_en,
    input logic              ovr_now,
    input logic              anc_q
);
    logic rd_stat;
    logic rd_other;
    assign rd_stat  = rd_en && (reg_addr == STAT_ADDR);
    assign rd_other = rd_en && (reg_addr != STAT_ADDR) && (reg_addr != XCTL_ADDR);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |-> (rd_data[10:7] == '0));                                  // R1
    AST_OVR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_addr == STAT_ADDR) && !ovr_now) |=> $stable(psup_en)); // R2
    AST_PSUP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |-> (rd_data[BIT_PSUP] == psup_en));                         // R3
    AST_ANC_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !an_en) |-> (rd_data[BIT_ANC] == 1'b0));                 // R5
    AST_ANC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (an_en && an_done && !an_restart) |=> anc_q);                        // R6
    AST_ANC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (anc_q && an_en && !rd_stat) |=> anc_q);                             // R7
    AST_CAP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |-> (rd_data[15:11] == CAP_HI && rd_data[4:0] == CAP_LO));   // R9
    AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other |-> (rd_data == '0));                                       // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));                                         // R11
endmodule

bind phy_stat_reg phy_stat_chk #(
    .STAT_ADDR (STAT_ADDR),
    .XCTL_ADDR (XCTL_ADDR),
    .CAP_HI    (CAP_HI),
    .CAP_LO    (CAP_LO)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .reg_addr   (reg_addr),
    .rd_data    (rd_data),
    .an_en      (an_en),
    .an_done    (an_done),
    .an_restart (an_restart),
    .psup_en    (psup_en),
    .ovr_now    (ovr_now),
    .anc_q      (anc_q)
);

// File: tb/test_phy_stat_reg.sv
`timescale 1ns/1ps
module test_phy_stat_reg;
    localparam logic [4:0] CAPH = 5'b01111;
    localparam logic [4:0] CAPL = 5'b01001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        an_en = 1'b0;
    logic        an_done = 1'b0;
    logic        an_restart = 1'b0;
    logic        psup_en;

    int n_chk = 0;
    int n_err = 0;
    logic exp_ovr = 1'b0;
    logic exp_psup = 1'b0;
    logic [15:0] d;

    always #10 clk = ~clk;

    phy_stat_reg #(
        .STAT_ADDR (5'd1),
        .XCTL_ADDR (5'd16),
        .CAP_HI    (CAPH),
        .CAP_LO    (CAPL)
    ) i_phy_stat_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .reg_addr   (reg_addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .an_en      (an_en),
        .an_done    (an_done),
        .an_restart (an_restart),
        .psup_en    (psup_en)
    );

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int a);
        if (a == 1)  return {CAPH, 4'b0000, exp_psup, 1'b0, CAPL};
        if (a == 16) return {exp_ovr, 15'b0};
        return 16'h0000;
    endfunction

    task automatic rd(input int a, output logic [15:0] q);
        @(negedge clk);
        rd_en = 1'b1;
        reg_addr = 5'(a);
        #2;
        q = rd_data;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        reg_addr = 5'(a);
        wr_data = v;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (a == 1 && exp_ovr) exp_psup = v[6];
        if (a == 16) exp_ovr = v[15];
    endtask

    task automatic anc_rd(input logic e, input string tag);
        rd(1, d);
        chk({15'b0, d[5]}, {15'b0, e}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'h0040; pats[3] = 16'hFFBF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state: R3 R4 R9 R11
        chk({15'b0, psup_en}, 16'h0000, "R3 reset psup_en");
        rd(1, d);  chk(d, {CAPH, 4'b0, 1'b0, 1'b0, CAPL}, "R9 reset status word");
        rd(16, d); chk(d, 16'h0000, "R4 reset override flag");
        @(negedge clk); reg_addr = 5'd1; #2;
        chk(rd_data, 16'h0000, "R11 idle read data");

        // near-exhaustive write sweep, override clear then set
        for (int ov = 0; ov < 2; ov++) begin
            for (int a = 0; a < 32; a++) begin
                for (int p = 0; p < 4; p++) begin
                    wr(16, ov[0] ? 16'h8000 : 16'h0000);
                    wr(a, pats[p]);
                    chk({15'b0, psup_en}, {15'b0, exp_psup}, "R2 R3 psup_en after write");
                    rd(1, d);
                    chk(d, exp_word(1), "R1 R2 R9 status word");
                    rd(a, d);
                    if (a == 16)     chk(d, exp_word(a), "R4 override readback");
                    else if (a != 1) chk(d, exp_word(a), "R10 unmapped read");
                end
            end
        end
        wr(16, 16'h0000);

        // completion latch scenarios
        an_en = 1'b1;
        anc_rd(1'b0, "R6 no completion yet");
        @(negedge clk); an_done = 1'b1; @(negedge clk); an_done = 1'b0;
        repeat (3) @(negedge clk);
        anc_rd(1'b1, "R6 held after done fell");
        anc_rd(1'b0, "R8 second read live");

        @(negedge clk); an_done = 1'b1; @(negedge clk); an_done = 1'b0; an_restart = 1'b1;
        repeat (5) @(negedge clk);
        anc_rd(1'b1, "R7 restart keeps held bit");
        anc_rd(1'b0, "R8 live after restart read");

        @(negedge clk); an_done = 1'b1;
        repeat (3) @(negedge clk);
        anc_rd(1'b0, "R7 restart blocks recording");
        an_restart = 1'b0;
        repeat (2) @(negedge clk);
        anc_rd(1'b1, "R6 done while held high");
        an_done = 1'b0;
        anc_rd(1'b1, "R8 reloaded at read edge");
        anc_rd(1'b0, "R8 cleared after live low");

        @(negedge clk); an_done = 1'b1; @(negedge clk); an_done = 1'b0; an_en = 1'b0;
        @(negedge clk);
        anc_rd(1'b0, "R5 disabled reads zero");
        an_en = 1'b1;
        anc_rd(1'b0, "R5 disable discarded held bit");
        an_en = 1'b0; an_done = 1'b1;
        repeat (2) @(negedge clk);
        anc_rd(1'b0, "R5 done ignored while disabled");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule